// File: doc/BRIEF.md
# Market Feed Message Field Extractor

This block sits behind a UDP receive path and turns the payload of each datagram into decoded fields of one binary market-data message. The first payload byte selects one of five message kinds. That byte also fixes the total length of the message and the byte offsets of the fields it carries. The block counts the bytes that follow and copies each field, most significant byte first, into an output register. When the last byte of the message arrives, it raises a general strobe and a strobe for that kind.

The field registers are never cleared between messages. A consumer in a slower clock domain can therefore sample them at leisure after the strobe, until a later message writes over them. A type byte the block does not recognise, or a payload that ends before the message is complete, produces an error strobe instead of a message strobe. A code on a separate output tells the two cases apart.

The input is a plain byte stream qualified by a per-byte valid. The block accepts a byte on every cycle in which valid is high and has no ready signal, so it never applies back-pressure. Cycles with valid low carry nothing, whatever the other inputs hold.

Top module: `feed_msg_extractor`

## Requirements
- R1: The type codes and total lengths are 0x41 (36 bytes), 0x45 (31), 0x58 (23), 0x53 (12) and 0x52 (39). After a recognised type byte, `msg_valid` pulses for exactly one cycle, in the cycle after the byte that completes that length is accepted.
- R2: `type_valid` is one-hot while `msg_valid` is high and zero otherwise. Bit 0 is 0x41, bit 1 is 0x45, bit 2 is 0x58, bit 3 is 0x53 and bit 4 is 0x52.
- R3: For every recognised kind, bytes 1-2 go to `locate`, bytes 3-4 to `tracking` and bytes 5-10 to `timestamp`. Each field is big-endian, so the earliest byte lands in the top bits.
- R4: Kind 0x41 fills `order_ref` from bytes 11-18, `side` from byte 19, `shares` from bytes 20-23, `symbol` from bytes 24-31 and `price` from bytes 32-35.
- R5: Kinds 0x45 and 0x58 fill `order_ref` from bytes 11-18 and `shares` from bytes 19-22. Kind 0x45 also fills `match_num` from bytes 23-30.
- R6: Kind 0x53 fills `event_code` from byte 11. Kind 0x52 fills `symbol` from bytes 11-18, `mkt_cat` from byte 19, `fin_status` from byte 20 and `round_lot` from bytes 21-24. Its bytes 25-38 are counted but not stored.
- R7: Reset sets every field register and `msg_type` to zero. After that, a field changes only when a byte at its offset is received for a kind that owns it. `msg_type` is loaded only from a recognised type byte, and a payload with an unrecognised type changes no field.
- R8: A type byte that is not one of the five codes gives one `err_valid` pulse, in the cycle after that byte, with `err_trunc` = 0. The rest of that payload is skipped, and no `msg_valid` follows for it.
- R9: If the payload-end byte arrives before a recognised message is complete, the block gives one `err_valid` pulse with `err_trunc` = 1 in the cycle after that byte, and no `msg_valid`. This includes a type byte that carries the end flag itself. A complete message gives no error.
- R10: An accepted byte with `in_end` set returns the block to idle. Bytes after a message completes, up to the payload end, have no effect. So do bytes accepted while idle without `in_start`.
- R11: Cycles with `in_valid` low are ignored, including their `in_start`, `in_end` and data. A message spread over idle cycles decodes the same as one sent back to back.
- R12: A byte with `in_start` always begins a new message. Any unfinished message is abandoned without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte on `in_data` is present this cycle |
| in_data | input | 8 | Payload byte |
| in_start | input | 1 | This byte is the first of a payload (the type byte) |
| in_end | input | 1 | This byte is the last of a payload |
| msg_valid | output | 1 | One-cycle pulse: a message was completed |
| type_valid | output | 5 | One-hot kind of the completed message |
| err_valid | output | 1 | One-cycle pulse: unknown type or truncated message |
| err_trunc | output | 1 | Cause of the last error: 1 truncated, 0 unknown type |
| msg_type | output | 8 | Type byte of the latest recognised message |
| locate | output | 16 | Locate code |
| tracking | output | 16 | Tracking number |
| timestamp | output | 48 | Timestamp |
| order_ref | output | 64 | Order reference |
| side | output | 8 | Buy/sell indicator |
| shares | output | 32 | Share count (added, executed or cancelled) |
| price | output | 32 | Price in 1/10000 dollar |
| symbol | output | 64 | Eight-character symbol |
| match_num | output | 64 | Match number |
| event_code | output | 8 | System event code |
| mkt_cat | output | 8 | Market category |
| fin_status | output | 8 | Financial status |
| round_lot | output | 32 | Round lot size |

## Verification
The bench truncates every recognised kind at every length short of complete, one-byte payloads included. A design with a length off by one would report a message there, or miss the error. It offers all 251 unrecognised type values with payloads of varied length, and then confirms that the fields and `msg_type` still hold the last good message. A design that parsed or cleared on a bad type would show different values. Messages are also sent with idle gaps carrying stray start and end flags, with trailing bytes past the message length, and with a new start cutting into an unfinished message. A design that counted idle cycles, let trailing bytes write over the price, or flagged the abandoned message would fail the field and strobe comparisons.

// File: rtl/feed_pkg.sv
package feed_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_KINDS = 5;
  localparam int MAX_LEN   = 39;
  localparam int IDX_W     = $clog2(MAX_LEN + 1);

  // one-hot positions of the message kinds
  localparam int K_ADD  = 0;
  localparam int K_EXEC = 1;
  localparam int K_CXL  = 2;
  localparam int K_EVT  = 3;
  localparam int K_DIR  = 4;

  typedef logic [NUM_KINDS-1:0] kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_SKIP = 2'd2
  } seq_state_t;

  function automatic logic [BYTE_W-1:0] kind_code(input int k);
    case (k)
      K_ADD:   return 8'h41;
      K_EXEC:  return 8'h45;
      K_CXL:   return 8'h58;
      K_EVT:   return 8'h53;
      default: return 8'h52;
    endcase
  endfunction

  function automatic int kind_len(input int k);
    case (k)
      K_ADD:   return 36;
      K_EXEC:  return 31;
      K_CXL:   return 23;
      K_EVT:   return 12;
      default: return 39;
    endcase
  endfunction
endpackage

// File: rtl/feed_type_decode.sv
module feed_type_decode
  import feed_pkg::*;
(
  input  logic [BYTE_W-1:0] code,
  output logic              known,
  output kind_t             kind,
  output logic [IDX_W-1:0]  total_len
);
  always_comb begin
    known     = 1'b0;
    kind      = '0;
    total_len = '0;
    for (int k = 0; k < NUM_KINDS; k++) begin
      if (code == kind_code(k)) begin
        known     = 1'b1;
        kind[k]   = 1'b1;
        total_len = IDX_W'(kind_len(k));
      end
    end
  end
endmodule

// File: rtl/feed_msg_seq.sv
module feed_msg_seq
  import feed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_start,
  input  logic              in_end,
  input  logic              dec_known,
  input  kind_t             dec_kind,
  input  logic [IDX_W-1:0]  dec_len,
  output logic              byte_wr,
  output logic [IDX_W-1:0]  byte_idx,
  output kind_t             cur_kind,
  output logic              msg_valid,
  output kind_t             type_valid,
  output logic              err_valid,
  output logic              err_trunc,
  output logic [BYTE_W-1:0] msg_type
);
  seq_state_t       state;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] len_q;
  logic             last_byte;

  assign last_byte = (cnt == len_q - IDX_W'(1));
  assign byte_wr   = in_valid && !in_start && (state == ST_RECV);
  assign byte_idx  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      len_q      <= '0;
      cur_kind   <= '0;
      msg_type   <= '0;
      msg_valid  <= 1'b0;
      type_valid <= '0;
      err_valid  <= 1'b0;
      err_trunc  <= 1'b0;
    end else begin
      msg_valid  <= 1'b0;
      type_valid <= '0;
      err_valid  <= 1'b0;
      if (in_valid) begin
        if (in_start) begin
          if (dec_known) begin
            cur_kind <= dec_kind;
            len_q    <= dec_len;
            msg_type <= in_data;
            cnt      <= IDX_W'(1);
            if (in_end) begin
              err_valid <= 1'b1;
              err_trunc <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= ST_RECV;
            end
          end else begin
            err_valid <= 1'b1;
            err_trunc <= 1'b0;
            state     <= in_end ? ST_IDLE : ST_SKIP;
          end
        end else begin
          case (state)
            ST_RECV: begin
              if (last_byte) begin
                msg_valid  <= 1'b1;
                type_valid <= cur_kind;
                state      <= in_end ? ST_IDLE : ST_SKIP;
              end else if (in_end) begin
                err_valid <= 1'b1;
                err_trunc <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                cnt <= cnt + IDX_W'(1);
              end
            end
            ST_SKIP: if (in_end) state <= ST_IDLE;
            default: ;
          endcase
        end
      end
    end
  end

  AST_KIND_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $countones(type_valid) == 1); // R2
  AST_KIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> type_valid == '0); // R2
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && err_valid)); // R9
  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end) |=> state == ST_IDLE); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV) |-> cnt < len_q); // R1
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |=> !msg_valid); // R8
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!msg_valid && !err_valid)); // R11
endmodule

// File: rtl/feed_field_reg.sv
module feed_field_reg
  import feed_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [IDX_W-1:0]     idx,
  input  logic [IDX_W-1:0]     base,
  input  logic [BYTE_W-1:0]    data,
  output logic [NB*BYTE_W-1:0] q
);
  logic [IDX_W-1:0] off;
  logic             hit;

  assign off = idx - base;
  assign hit = wr && (idx >= base) && (int'(off) < NB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (hit) q[BYTE_W*(NB-1-int'(off)) +: BYTE_W] <= data;
  end

  AST_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q)); // R7
endmodule

// File: rtl/feed_field_bank.sv
module feed_field_bank
  import feed_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  kind_t             kind,
  input  logic [BYTE_W-1:0] data,
  output logic [15:0]       locate,
  output logic [15:0]       tracking,
  output logic [47:0]       timestamp,
  output logic [63:0]       order_ref,
  output logic [7:0]        side,
  output logic [31:0]       shares,
  output logic [31:0]       price,
  output logic [63:0]       symbol,
  output logic [63:0]       match_num,
  output logic [7:0]        event_code,
  output logic [7:0]        mkt_cat,
  output logic [7:0]        fin_status,
  output logic [31:0]       round_lot
);
  logic wr_order, wr_add, wr_exec, wr_evt, wr_dir, wr_sym;
  logic [IDX_W-1:0] qty_base, sym_base;

  assign wr_order = wr && (kind[K_ADD] || kind[K_EXEC] || kind[K_CXL]);
  assign wr_add   = wr && kind[K_ADD];
  assign wr_exec  = wr && kind[K_EXEC];
  assign wr_evt   = wr && kind[K_EVT];
  assign wr_dir   = wr && kind[K_DIR];
  assign wr_sym   = wr && (kind[K_ADD] || kind[K_DIR]);
  assign qty_base = kind[K_ADD] ? IDX_W'(20) : IDX_W'(19);
  assign sym_base = kind[K_ADD] ? IDX_W'(24) : IDX_W'(11);

  feed_field_reg #(.NB(2)) u_loc (.clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx),
    .base(IDX_W'(1)), .data(data), .q(locate));
  feed_field_reg #(.NB(2)) u_trk (.clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx),
    .base(IDX_W'(3)), .data(data), .q(tracking));
  feed_field_reg #(.NB(6)) u_ts (.clk(clk), .rst_n(rst_n), .wr(wr), .idx(idx),
    .base(IDX_W'(5)), .data(data), .q(timestamp));
  feed_field_reg #(.NB(8)) u_ref (.clk(clk), .rst_n(rst_n), .wr(wr_order), .idx(idx),
    .base(IDX_W'(11)), .data(data), .q(order_ref));
  feed_field_reg #(.NB(1)) u_side (.clk(clk), .rst_n(rst_n), .wr(wr_add), .idx(idx),
    .base(IDX_W'(19)), .data(data), .q(side));
  feed_field_reg #(.NB(4)) u_qty (.clk(clk), .rst_n(rst_n), .wr(wr_order), .idx(idx),
    .base(qty_base), .data(data), .q(shares));
  feed_field_reg #(.NB(4)) u_px (.clk(clk), .rst_n(rst_n), .wr(wr_add), .idx(idx),
    .base(IDX_W'(32)), .data(data), .q(price));
  feed_field_reg #(.NB(8)) u_sym (.clk(clk), .rst_n(rst_n), .wr(wr_sym), .idx(idx),
    .base(sym_base), .data(data), .q(symbol));
  feed_field_reg #(.NB(8)) u_match (.clk(clk), .rst_n(rst_n), .wr(wr_exec), .idx(idx),
    .base(IDX_W'(23)), .data(data), .q(match_num));
  feed_field_reg #(.NB(1)) u_evt (.clk(clk), .rst_n(rst_n), .wr(wr_evt), .idx(idx),
    .base(IDX_W'(11)), .data(data), .q(event_code));
  feed_field_reg #(.NB(1)) u_mkt (.clk(clk), .rst_n(rst_n), .wr(wr_dir), .idx(idx),
    .base(IDX_W'(19)), .data(data), .q(mkt_cat));
  feed_field_reg #(.NB(1)) u_fin (.clk(clk), .rst_n(rst_n), .wr(wr_dir), .idx(idx),
    .base(IDX_W'(20)), .data(data), .q(fin_status));
  feed_field_reg #(.NB(4)) u_lot (.clk(clk), .rst_n(rst_n), .wr(wr_dir), .idx(idx),
    .base(IDX_W'(21)), .data(data), .q(round_lot));

  AST_KIND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> $onehot(kind)); // R2
endmodule

// File: rtl/feed_msg_extractor.sv
module feed_msg_extractor
  import feed_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_start,
  input  logic        in_end,
  output logic        msg_valid,
  output logic [4:0]  type_valid,
  output logic        err_valid,
  output logic        err_trunc,
  output logic [7:0]  msg_type,
  output logic [15:0] locate,
  output logic [15:0] tracking,
  output logic [47:0] timestamp,
  output logic [63:0] order_ref,
  output logic [7:0]  side,
  output logic [31:0] shares,
  output logic [31:0] price,
  output logic [63:0] symbol,
  output logic [63:0] match_num,
  output logic [7:0]  event_code,
  output logic [7:0]  mkt_cat,
  output logic [7:0]  fin_status,
  output logic [31:0] round_lot
);
  logic             dec_known;
  kind_t            dec_kind;
  logic [IDX_W-1:0] dec_len;
  logic             byte_wr;
  logic [IDX_W-1:0] byte_idx;
  kind_t            cur_kind;

  feed_type_decode u_dec (
    .code(in_data), .known(dec_known), .kind(dec_kind), .total_len(dec_len)
  );

  feed_msg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_start(in_start), .in_end(in_end), .dec_known(dec_known),
    .dec_kind(dec_kind), .dec_len(dec_len), .byte_wr(byte_wr),
    .byte_idx(byte_idx), .cur_kind(cur_kind), .msg_valid(msg_valid),
    .type_valid(type_valid), .err_valid(err_valid), .err_trunc(err_trunc),
    .msg_type(msg_type)
  );

  feed_field_bank u_bank (
    .clk(clk), .rst_n(rst_n), .wr(byte_wr), .idx(byte_idx), .kind(cur_kind),
    .data(in_data), .locate(locate), .tracking(tracking), .timestamp(timestamp),
    .order_ref(order_ref), .side(side), .shares(shares), .price(price),
    .symbol(symbol), .match_num(match_num), .event_code(event_code),
    .mkt_cat(mkt_cat), .fin_status(fin_status), .round_lot(round_lot)
  );

  AST_TYPE_HELD_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_start && !dec_known) |=> $stable(msg_type)); // R7
endmodule

// File: tb/feed_msg_extractor_test.sv
module feed_msg_extractor_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        in_valid, in_start, in_end;
  logic [7:0]  in_data;
  logic        msg_valid, err_valid, err_trunc;
  logic [4:0]  type_valid;
  logic [7:0]  msg_type, side, event_code, mkt_cat, fin_status;
  logic [15:0] locate, tracking;
  logic [47:0] timestamp;
  logic [63:0] order_ref, symbol, match_num;
  logic [31:0] shares, price, round_lot;

  int n_chk = 0, n_bad = 0;
  int n_mv = 0, n_err = 0;
  logic [4:0] tv_seen = '0;
  logic last_trunc = 1'b0;

  feed_msg_extractor uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_start(in_start), .in_end(in_end), .msg_valid(msg_valid),
    .type_valid(type_valid), .err_valid(err_valid), .err_trunc(err_trunc),
    .msg_type(msg_type), .locate(locate), .tracking(tracking),
    .timestamp(timestamp), .order_ref(order_ref), .side(side), .shares(shares),
    .price(price), .symbol(symbol), .match_num(match_num),
    .event_code(event_code), .mkt_cat(mkt_cat), .fin_status(fin_status),
    .round_lot(round_lot)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n) begin
    if (msg_valid) begin n_mv++; tv_seen = type_valid; end
    if (err_valid) begin n_err++; last_trunc = err_trunc; end
  end

  function automatic logic [7:0] bcode(input int k);
    case (k)
      0: return 8'h41; 1: return 8'h45; 2: return 8'h58; 3: return 8'h53;
      default: return 8'h52;
    endcase
  endfunction

  function automatic int blen(input int k);
    case (k)
      0: return 36; 1: return 31; 2: return 23; 3: return 12;
      default: return 39;
    endcase
  endfunction

  function automatic logic [7:0] bv(input int seed, input int i);
    return 8'((seed * 29 + i * 13 + 7) & 255);
  endfunction

  function automatic logic [63:0] fx(input int seed, input int s, input int n);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r = (r << 8) | 64'(bv(seed, s + k));
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] t, input int seed, input int nb,
                      input bit gaps, input bit with_end);
    for (int i = 0; i < nb; i++) begin
      if (gaps && (i % 3 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b1; in_end = 1'b1; in_data = 8'hA5;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (i == 0);
      in_end   = with_end && (i == nb - 1);
      in_data  = (i == 0) ? t : bv(seed, i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0; in_data = '0;
  endtask

  task automatic check_fields(input int k, input int seed);
    chk("R3 locate", 64'(locate), fx(seed, 1, 2));
    chk("R3 tracking", 64'(tracking), fx(seed, 3, 2));
    chk("R3 timestamp", 64'(timestamp), fx(seed, 5, 6));
    case (k)
      0: begin
        chk("R4 order_ref", order_ref, fx(seed, 11, 8));
        chk("R4 side", 64'(side), fx(seed, 19, 1));
        chk("R4 shares", 64'(shares), fx(seed, 20, 4));
        chk("R4 symbol", symbol, fx(seed, 24, 8));
        chk("R4 price", 64'(price), fx(seed, 32, 4));
      end
      1: begin
        chk("R5 exec order_ref", order_ref, fx(seed, 11, 8));
        chk("R5 exec shares", 64'(shares), fx(seed, 19, 4));
        chk("R5 match_num", match_num, fx(seed, 23, 8));
      end
      2: begin
        chk("R5 cancel order_ref", order_ref, fx(seed, 11, 8));
        chk("R5 cancel shares", 64'(shares), fx(seed, 19, 4));
      end
      3: chk("R6 event_code", 64'(event_code), fx(seed, 11, 1));
      default: begin
        chk("R6 dir symbol", symbol, fx(seed, 11, 8));
        chk("R6 mkt_cat", 64'(mkt_cat), fx(seed, 19, 1));
        chk("R6 fin_status", 64'(fin_status), fx(seed, 20, 1));
        chk("R6 round_lot", 64'(round_lot), fx(seed, 21, 4));
      end
    endcase
  endtask

  task automatic run_good(input int k, input int seed, input bit gaps, input int extra);
    int m0, e0;
    m0 = n_mv; e0 = n_err;
    send(bcode(k), seed, blen(k) + extra, gaps, 1'b1);
    if (extra == 0) begin
      chk("R1 strobe in cycle after last byte", 64'(msg_valid), 64'd1);
      @(negedge clk);
      chk("R1 strobe one cycle wide", 64'(msg_valid), 64'd0);
    end
    settle();
    chk("R1 one message strobe", 64'(n_mv - m0), 64'd1);
    chk("R9 no error on complete message", 64'(n_err - e0), 64'd0);
    chk("R2 kind bit", 64'(tv_seen), 64'(5'b1 << k));
    chk("R7 msg_type", 64'(msg_type), 64'(bcode(k)));
    check_fields(k, seed);
  endtask

  function automatic bit is_known(input int v);
    for (int k = 0; k < 5; k++) if (v == int'(bcode(k))) return 1'b1;
    return 1'b0;
  endfunction

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int m0, e0;
    rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset msg_valid", 64'(msg_valid), 64'd0);
    chk("R7 reset err_valid", 64'(err_valid), 64'd0);
    chk("R7 reset locate", 64'(locate), 64'd0);
    chk("R7 reset symbol", symbol, 64'd0);
    chk("R7 reset msg_type", 64'(msg_type), 64'd0);
    rst_n = 1'b1;
    settle();

    // R10: bytes while idle without a start
    m0 = n_mv; e0 = n_err;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_start = 1'b0; in_end = (i == 4); in_data = 8'h41;
    end
    @(negedge clk);
    in_valid = 1'b0; in_end = 1'b0;
    settle();
    chk("R10 idle bytes give no message", 64'(n_mv - m0), 64'd0);
    chk("R10 idle bytes give no error", 64'(n_err - e0), 64'd0);
    chk("R10 idle bytes leave locate", 64'(locate), 64'd0);

    // R1-R6, R11: every kind, several seeds, with and without gaps
    for (int k = 0; k < 5; k++)
      for (int s = 1; s <= 4; s++)
        run_good(k, s + 10 * k, s[0], 0);

    // R10: trailing bytes after a complete message
    run_good(0, 9, 1'b0, 5);

    // R8: every unrecognised type value
    for (int v = 0; v < 256; v++) begin
      if (!is_known(v)) begin
        m0 = n_mv; e0 = n_err;
        send(8'(v), 50, (v == 90) ? 40 : 1 + (v % 4), 1'b0, 1'b1);
        settle();
        chk("R8 unknown type error count", 64'(n_err - e0), 64'd1);
        chk("R8 unknown type cause", 64'(last_trunc), 64'd0);
        chk("R8 unknown type no message", 64'(n_mv - m0), 64'd0);
      end
    end
    chk("R7 locate held over unknown", 64'(locate), fx(9, 1, 2));
    chk("R7 price held over unknown", 64'(price), fx(9, 32, 4));
    chk("R7 msg_type held over unknown", 64'(msg_type), 64'h41);

    // R9: every truncation point of every kind
    for (int k = 0; k < 5; k++)
      for (int n = 1; n < blen(k); n++) begin
        m0 = n_mv; e0 = n_err;
        send(bcode(k), 60 + n, n, 1'b0, 1'b1);
        settle();
        chk("R9 truncation error count", 64'(n_err - e0), 64'd1);
        chk("R9 truncation cause", 64'(last_trunc), 64'd1);
        chk("R9 truncation no message", 64'(n_mv - m0), 64'd0);
      end

    // R12: new start cuts into an unfinished message
    m0 = n_mv; e0 = n_err;
    send(8'h41, 5, 6, 1'b0, 1'b0);
    send(8'h53, 77, 12, 1'b0, 1'b1);
    settle();
    chk("R12 restart gives one message", 64'(n_mv - m0), 64'd1);
    chk("R12 abandoned message not reported", 64'(n_err - e0), 64'd0);
    chk("R12 restart kind", 64'(tv_seen), 64'(5'b01000));
    chk("R12 restart event_code", 64'(event_code), fx(77, 11, 1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule